// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block sits in the scanout path of a frame buffer in which every pixel has three companion words: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. It consumes one pixel per accepted input beat. It decides per pixel whether the direct colour or the palette colour of the index is shown. It then emits a 32-bit pixel packed in RGB or BGR byte order on a ready/valid output stream.

The block keeps one column/line counter that all three planes share. It publishes the counter as the fetch address of the next pixel it expects. The address is line times the fixed line stride plus the column, so the memory side can fetch all three planes with one address. Every line is `STRIDE` pixels long in memory. Only the first `cfg_width` columns of each line reach the output. A frame has `cfg_height` lines. Palette lookups are issued to an external table with one cycle of read latency. Direct-colour pixels travel through the same two register stages, so pixels leave in the order they arrived.

Top module: `mixdepth_pix_sel`

## Requirements
- R1: When bits 31:24 of `in_ctl` equal 0x03, the emitted colour is taken from `in_dir`, with blue in bits 23:16, green in bits 15:8 and red in bits 7:0. Bits 31:24 of `in_dir` and bits 23:0 of `in_ctl` are ignored. Both words arrive already assembled big-endian, so the byte at the lowest address is in bits 31:24.
- R2: For any other control code, the block raises `pal_rd` with `pal_idx` equal to `in_idx` in the cycle the pixel is accepted. It uses `pal_data` (red 23:16, green 15:8, blue 7:0) as sampled in the following cycle.
- R3: With `cfg_bgr` low, the output is {8'h00, R, G, B}. With `cfg_bgr` high, it is {8'h00, B, G, R}.
- R4: Input pixels whose column is `cfg_width` or more are accepted but produce no output. A frame yields exactly `cfg_width` × `cfg_height` output pixels.
- R5: `fetch_addr` equals line × `STRIDE` + column of the next expected input pixel. The column wraps from `STRIDE`-1 to 0 and advances the line. The line wraps from `cfg_height`-1 to 0. The address moves only when an input pixel is accepted.
- R6: Under any pattern of `out_ready` and `in_valid`, no pixel is lost, duplicated or reordered. While `out_valid` is high and `out_ready` is low, `out_pixel` holds its value.
- R7: After reset, `out_valid` is 0, `fetch_addr` is 0 and `in_ready` is 1.
- R8: A palette pixel stalled in the pipeline keeps the colour returned one cycle after its lookup, even though `pal_data` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bgr | input | 1 | Output packing: 0 RGB, 1 BGR |
| cfg_width | input | WID_W | Active pixels per line (1..STRIDE) |
| cfg_height | input | HGT_W | Lines per frame (1..MAX_H) |
| fetch_addr | output | ADDR_W | Shared plane address of the next expected pixel |
| in_valid | input | 1 | Input pixel words valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_idx | input | 8 | Indexed-plane value |
| in_dir | input | 32 | Direct-colour plane word |
| in_ctl | input | 32 | Control plane word |
| pal_rd | output | 1 | Palette lookup strobe |
| pal_idx | output | 8 | Palette lookup index |
| pal_data | input | 24 | Palette entry {R,G,B}, one cycle after the lookup |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
The outputs expose internal errors quickly. A stale palette hold register shows as a wrong colour on the first palette pixel that is stalled for more than one cycle. A wrong stage-advance condition shows within a few cycles of backpressure as a missing, repeated or out-of-order pixel in the output sequence. A miscounted column or line shows on `fetch_addr` at the very next accepted beat. It also changes the number of pixels a frame yields by the frame's end.

// File: rtl/mixdepth_pix_sel.sv
module mixdepth_pix_sel #(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768,
  localparam int COL_W  = $clog2(STRIDE),
  localparam int LINE_W = $clog2(MAX_H),
  localparam int WID_W  = $clog2(STRIDE + 1),
  localparam int HGT_W  = $clog2(MAX_H + 1),
  localparam int ADDR_W = COL_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bgr,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [HGT_W-1:0]  cfg_height,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_idx,
  input  logic [31:0]       in_dir,
  input  logic [31:0]       in_ctl,
  output logic              pal_rd,
  output logic [7:0]        pal_idx,
  input  logic [23:0]       pal_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_pixel
);

  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic              s1_valid, s1_dir, s1_fresh;
  logic [23:0]       s1_rgb, s1_pal_hold;

  wire acc      = in_valid && in_ready;
  wire keep     = int'(col) < int'(cfg_width);
  wire use_dir  = in_ctl[31:24] == 8'h03;
  wire col_end  = int'(col) == STRIDE - 1;
  wire line_end = (int'(line) == int'(cfg_height) - 1) || (int'(line) == MAX_H - 1);

  wire s2_free  = !out_valid || out_ready;
  wire s1_free  = !s1_valid || s2_free;

  wire [23:0] s1_pal   = s1_fresh ? pal_data : s1_pal_hold;
  wire [23:0] s1_color = s1_dir ? s1_rgb : s1_pal;

  assign in_ready   = s1_free;
  assign fetch_addr = {line, col};
  assign pal_rd     = acc && keep && !use_dir;
  assign pal_idx    = in_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col  <= '0;
      line <= '0;
    end else if (acc) begin
      if (col_end) begin
        col  <= '0;
        line <= line_end ? '0 : line + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_dir      <= 1'b0;
      s1_fresh    <= 1'b0;
      s1_rgb      <= '0;
      s1_pal_hold <= '0;
    end else if (s1_free) begin
      s1_valid <= acc && keep;
      s1_dir   <= use_dir;
      s1_rgb   <= {in_dir[7:0], in_dir[15:8], in_dir[23:16]};
      s1_fresh <= 1'b1;
    end else begin
      s1_fresh <= 1'b0;
      if (s1_fresh) s1_pal_hold <= pal_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else if (s2_free) begin
      out_valid <= s1_valid;
      out_pixel <= cfg_bgr ? {8'h00, s1_color[7:0], s1_color[15:8], s1_color[23:16]}
                           : {8'h00, s1_color};
    end
  end

endmodule

// File: rtl/mixdepth_pix_sel_chk.sv
module mixdepth_pix_sel_chk #(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768,
  localparam int COL_W  = $clog2(STRIDE),
  localparam int LINE_W = $clog2(MAX_H),
  localparam int ADDR_W = COL_W + LINE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_ctl,
  input logic              pal_rd,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_pixel
);

  wire acc = in_valid && in_ready;

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));

  assert_top_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pixel[31:24] == 8'h00);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (int'(fetch_addr[COL_W-1:0]) != STRIDE - 1)
      |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  assert_addr_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(fetch_addr));

  assert_lookup_only_palette_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd |-> acc && in_ctl[31:24] != 8'h03);

  assert_direct_no_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_ctl[31:24] == 8'h03 |-> !pal_rd);

endmodule

bind mixdepth_pix_sel mixdepth_pix_sel_chk #(.STRIDE(STRIDE), .MAX_H(MAX_H)) u_chk (.*);

// File: tb/mixdepth_pix_sel_bench.sv
module mixdepth_pix_sel_bench;
  localparam int STRIDE = 8;
  localparam int MAX_H  = 4;
  localparam int COL_W  = $clog2(STRIDE);
  localparam int LINE_W = $clog2(MAX_H);
  localparam int WID_W  = $clog2(STRIDE + 1);
  localparam int HGT_W  = $clog2(MAX_H + 1);
  localparam int ADDR_W = COL_W + LINE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bgr = 1'b0;
  logic [WID_W-1:0] cfg_width = WID_W'(STRIDE);
  logic [HGT_W-1:0] cfg_height = HGT_W'(MAX_H);
  logic [ADDR_W-1:0] fetch_addr;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_idx = '0;
  logic [31:0] in_dir = '0, in_ctl = '0;
  logic pal_rd;
  logic [7:0] pal_idx;
  logic [23:0] pal_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [31:0] out_pixel;

  int checks = 0, failures = 0, cyc = 0, seq = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  mixdepth_pix_sel #(.STRIDE(STRIDE), .MAX_H(MAX_H)) u_mixdepth_pix_sel (.*);

  function automatic logic [23:0] pal_f(logic [7:0] i);
    return {i ^ 8'h5A, i + 8'd1, ~i};
  endfunction
  function automatic logic [7:0] code_of(int k);
    case (k % 6)
      0, 3:    return 8'h03;
      1:       return 8'h02;
      2:       return 8'h83;
      4:       return 8'h00;
      default: return 8'h13;
    endcase
  endfunction

  always @(posedge clk) pal_data <= pal_rd ? pal_f(pal_idx) : 24'hC3C3C3;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_frame(bit bgr, int w, int h, int mode);
    int sent = 0, outs = 0, col = 0, line = 0;
    int total = STRIDE * h;
    cfg_bgr = bgr;
    cfg_width = WID_W'(w);
    cfg_height = HGT_W'(h);
    while (sent < total || exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      case (mode)
        0: begin out_ready = 1'b1; in_valid = sent < total; end
        1: begin out_ready = (cyc % 3) != 0; in_valid = (sent < total) && (cyc % 5 != 2); end
        default: begin out_ready = (cyc % 4) == 0; in_valid = sent < total; end
      endcase
      in_idx = 8'(seq * 37 + 5);
      in_ctl = {code_of(seq), 24'(seq * 1001)};
      in_dir = {8'(seq * 13), 8'(seq * 29 + 1), 8'(seq * 7 + 2), 8'(seq * 3 + 9)};
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R6 extra", out_pixel, 32'h0);
        else begin
          check(out_pixel == exp_q[0], tag_q[0], out_pixel, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        outs++;
      end
      if (in_valid && in_ready) begin
        logic [23:0] rgb;
        string t;
        check(fetch_addr == ADDR_W'(line * STRIDE + col), "R5", 32'(fetch_addr),
              32'(line * STRIDE + col));
        if (col < w) begin
          if (in_ctl[31:24] == 8'h03) begin
            rgb = {in_dir[7:0], in_dir[15:8], in_dir[23:16]};
            t = "R1 R3";
          end else begin
            rgb = pal_f(in_idx);
            t = "R2 R3";
          end
          if (mode != 0) t = {t, " R6 R8"};
          exp_q.push_back(bgr ? {8'h00, rgb[7:0], rgb[15:8], rgb[23:16]} : {8'h00, rgb});
          tag_q.push_back(t);
        end
        sent++;
        seq++;
        if (col == STRIDE - 1) begin
          col = 0;
          line = (line == h - 1) ? 0 : line + 1;
        end else col++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(outs == w * h, "R4 count", 32'(outs), 32'(w * h));
    check(!out_valid, "R4 none after frame", 32'(out_valid), 32'h0);
  endtask

  initial begin
    #120000;
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R7 out_valid", 32'(out_valid), 32'h0);
    check(fetch_addr == '0, "R7 fetch_addr", 32'(fetch_addr), 32'h0);
    check(in_ready, "R7 in_ready", 32'(in_ready), 32'h1);
    run_frame(1'b0, 5, 3, 0);
    run_frame(1'b1, 5, 3, 1);
    run_frame(1'b0, STRIDE, MAX_H, 2);
    run_frame(1'b1, 1, 1, 1);
    run_frame(1'b1, 3, 2, 2);
    run_frame(1'b0, STRIDE, 1, 1);
    finish_run();
  end
endmodule